// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block divides its input clock by a 16-bit divisor and produces a clock at sixteen times the serial bit rate. The transmit shifter and the receive sampler run from that clock. The divisor sits in two byte-wide registers. Each register has its own write strobe, and any write restarts the count at once, so a new rate never waits for an old long period to run out.

For any divisor of 3 or more, the output is low for the first two input clocks of each period and high for the rest. Three small values work differently. A divisor of 0 behaves like a period of 3. A divisor of 1 passes the inverted input clock straight through. A divisor of 2 gives a square wave with 50% duty. A registered single-cycle tick marks the last input clock of every period, so logic on the same clock can use it as an enable.

Top module: `bbr_gen`

## Requirements
- R1: Synchronous active-high reset clears both divisor bytes to zero and starts a fresh period: while reset is held, and on the first clock after it, the output is low and the tick is low.
- R2: A write strobe on the low byte loads bits 7:0 of the divisor from the write data, and a write strobe on the high byte loads bits 15:8. Both strobes may be asserted in the same cycle, in which case both bytes take the same data.
- R3: The clock edge that captures any write starts a new period. In the following cycle the block is in phase 0 of a period of the new length, and its output is low.
- R4: A divisor of 0 gives a period of 3 input clocks: low for 2, then high for 1.
- R5: A divisor of 1 makes the output the logical inverse of the input clock, and the tick is high on every cycle.
- R6: A divisor of 2 makes the output alternate low and high on successive input clocks, starting low.
- R7: A divisor N of 3 or more (up to 65535) gives a period of N input clocks: low for the first 2 and high for the remaining N-2. Periods follow one another without a gap.
- R8: For every divisor other than 1, the tick is high for exactly one input clock per period, on the last clock of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write strobe for divisor bits 7:0 |
| wr_hi | input | 1 | Write strobe for divisor bits 15:8 |
| wr_data | input | 8 | Byte written by either strobe |
| baud_clk | output | 1 | Output clock at 16x the bit rate |
| baud_tick | output | 1 | One-cycle pulse on the last clock of each period |

## Verification
The assertions assume that the write strobes and the write data are synchronous to the input clock and stable around the rising edge. They also assume that reset is asserted at time zero. The bench keeps within this by driving every input on the falling edge. It also holds reset for several cycles before releasing it. The bypass output for a divisor of 1 follows the clock level between edges, and no clocked property can see that. For this reason the bench samples it separately, a quarter period after each rising edge, when the clock is high.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  // period used when the divisor register holds zero
  localparam int unsigned ZERO_PERIOD = 3;
  // divisor value that selects the clock-inversion bypass
  localparam int unsigned BYPASS_DIV  = 1;
  // divisor value that selects the square wave
  localparam int unsigned SQUARE_DIV  = 2;
  // number of low input clocks at the start of a shaped period
  localparam int unsigned LOW_CLOCKS  = 2;
endpackage

// File: rtl/bbr_latch.sv
module bbr_latch #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NB     = 2,
  localparam int unsigned DIV_W = BYTE_W * NB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NB-1:0]     wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_d,
  output logic              load
);
  assign load = |wr_en;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign div_d[b*BYTE_W +: BYTE_W] = wr_en[b] ? wr_data : div_q[b*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
      if (rst) div_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en[b]) div_q[b*BYTE_W +: BYTE_W] <= wr_data;
    end

    // R2: a strobed byte holds the written data on the next cycle
    assert_byte_write_R2: assert property (@(posedge clk) disable iff (rst)
      wr_en[b] |=> div_q[b*BYTE_W +: BYTE_W] == $past(wr_data));
  end
endmodule

// File: rtl/bbr_counter.sv
module bbr_counter
  import bbr_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_d,
  input  logic [DIV_W-1:0] div_q,
  input  logic             load,
  output logic [DIV_W-1:0] cnt_nxt,
  output logic [DIV_W-1:0] eff_d,
  output logic             tick_q
);
  localparam logic [DIV_W-1:0] ZMAP  = DIV_W'(ZERO_PERIOD);
  localparam logic [DIV_W-1:0] ONE_W = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_q;

  assign eff_d   = (div_d == '0) ? ZMAP : div_d;
  assign eff_q   = (div_q == '0) ? ZMAP : div_q;
  assign cnt_nxt = (load || cnt_q == '0) ? (eff_d - ONE_W) : (cnt_q - ONE_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ZMAP - ONE_W;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      tick_q <= (cnt_nxt == '0);
    end
  end

  // R7: the phase counter never exceeds the period of the held divisor
  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= eff_q - ONE_W);

  // R3: a write restarts the count at the top of the new period
  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == eff_q - ONE_W);

  // R8: with a period of 2 or more, the tick never lasts two cycles
  assert_tick_single_R8: assert property (@(posedge clk) disable iff (rst)
    (tick_q && div_q != DIV_W'(BYPASS_DIV) && !load) |=> !tick_q);
endmodule

// File: rtl/bbr_shaper.sv
module bbr_shaper
  import bbr_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cnt_nxt,
  input  logic [DIV_W-1:0] eff_d,
  output logic             out_q
);
  localparam logic [DIV_W-1:0] SQW  = DIV_W'(SQUARE_DIV);
  localparam logic [DIV_W-1:0] LOWN = DIV_W'(LOW_CLOCKS);

  logic low_d;

  // the counter runs down, so phase p equals (period - 1 - count)
  always_comb begin
    if (eff_d == SQW) low_d = (cnt_nxt == DIV_W'(1));
    else              low_d = (eff_d > LOWN) && (cnt_nxt >= eff_d - LOWN);
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= ~low_d;
  end

  // R1: the shaped output leaves reset in its low phase
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !out_q);
endmodule

// File: rtl/bbr_gen.sv
module bbr_gen
  import bbr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB    = 2,
  localparam int unsigned DIV_W = BYTE_W * NB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              baud_clk,
  output logic              baud_tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] eff_d;
  logic             load;
  logic             shaped;
  logic             bypass;

  bbr_latch #(.BYTE_W(BYTE_W), .NB(NB)) u_latch (
    .clk(clk), .rst(rst), .wr_en({wr_hi, wr_lo}), .wr_data(wr_data),
    .div_q(div_q), .div_d(div_d), .load(load)
  );

  bbr_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .div_d(div_d), .div_q(div_q), .load(load),
    .cnt_nxt(cnt_nxt), .eff_d(eff_d), .tick_q(baud_tick)
  );

  bbr_shaper #(.DIV_W(DIV_W)) u_shape (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .eff_d(eff_d), .out_q(shaped)
  );

  assign bypass   = (div_q == DIV_W'(BYPASS_DIV));
  assign baud_clk = bypass ? ~clk : shaped;

  // R6: a divisor of 2 flips the shaped output every clock
  assert_square_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (div_q == DIV_W'(SQUARE_DIV) && !load) |=> shaped != $past(shaped));

  // R5: a divisor of 1 keeps the tick high
  assert_bypass_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (div_q == DIV_W'(BYPASS_DIV) && !load) |=> baud_tick);
endmodule

// File: tb/bbr_gen_tb.sv
module bbr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_lo = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       baud_clk;
  logic       baud_tick;

  int total = 0;
  int bad   = 0;
  string tag = "R1";

  // behavioural reference state
  int m_div   = 0;
  int m_phase = 0;
  bit m_fresh = 1'b0;

  bbr_gen u_dut (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .baud_clk(baud_clk), .baud_tick(baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period_of(int d);
    return (d == 0) ? 3 : d;
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b div=%0d phase=%0d",
               req, $time, act, exp, m_div, m_phase);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_phase = 0; m_fresh = 1'b0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) m_div = (m_div & 32'hFF00) | int'(wr_data);
      if (wr_hi) m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
      m_phase = 0; m_fresh = 1'b1;
    end else begin
      m_phase = (m_phase + 1) % period_of(m_div);
      m_fresh = 1'b0;
    end
  end

  // compare at the falling edge, when the clock is low
  always @(negedge clk) begin
    int n;
    logic exp_out;
    n = period_of(m_div);
    if (n == 1)      exp_out = 1'b1;
    else if (n == 2) exp_out = (m_phase != 0);
    else             exp_out = (m_phase >= 2);
    check(m_fresh ? "R3" : tag, baud_clk, exp_out);
    check((n == 1) ? "R5" : "R8", baud_tick, logic'(m_phase == n - 1));
  end

  // R5: the bypass output is low while the input clock is high
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst && period_of(m_div) == 1) check("R5", baud_clk, 1'b0);
  end

  task automatic wr(bit lo, bit hi, logic [7:0] d);
    @(negedge clk);
    wr_lo = lo; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1";
    run(4);
    @(negedge clk); rst = 1'b0;
    tag = "R4"; run(12);              // divisor 0 behaves as a period of 3
    tag = "R6"; wr(1, 0, 8'd2); run(11);
    tag = "R5"; wr(1, 0, 8'd1); run(9);
    tag = "R7"; wr(1, 0, 8'd5); run(7);
    wr(1, 0, 8'd7); run(23);          // R3 rewrite mid-period
    tag = "R2"; wr(0, 1, 8'd1); run(600);  // 0x0107
    wr(1, 1, 8'd0); tag = "R4"; run(9);    // both strobes, back to 0
    tag = "R7"; wr(1, 0, 8'd3); run(14);
    wr(1, 1, 8'hFF); run(66000);      // largest divisor
    tag = "R1"; @(negedge clk); rst = 1'b1; run(3);
    @(negedge clk); rst = 1'b0;
    tag = "R4"; run(8);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule